// File: doc/BRIEF.md
# Bi-quinary decade divider counter

This block is a small counter made of two sections: a divide-by-2 stage whose count input is `cp0` and a divide-by-5 stage whose count input is `cp1`. One master reset clears both. Each section steps when its count input goes from high to low. The count inputs are not used as clocks. A single system clock samples them through a synchronizer, and each falling edge becomes a one-cycle advance pulse. The block therefore has only one clock domain, and all output bits change on the same clock edge.

The `mode` input selects how the two sections are chained:

- **Decade mode** (`mode`=0): the input signal goes to `cp0`. The falling edge of the divide-by-2 output advances the divide-by-5 section. The outputs then count 0 to 9 in weighted 8-4-2-1 binary.
- **Symmetric mode** (`mode`=1): the input signal goes to `cp1`. The falling edge of the top bit of the divide-by-5 section toggles the divide-by-2 stage. `q[0]` then becomes a divide-by-10 output with a 50% duty cycle.

In both modes, the count input of the section that is being fed is ignored. A terminal-count flag pulses when the combined count wraps back to zero.

Top module: `decade_divider`

## Requirements
- R1: A section advances only on a high-to-low transition of its count source. A low-to-high transition, or a level held steady, leaves `q` unchanged.
- R2: While `mr` is 1, `q` is 0 and `tc` is 0. An input edge whose update would fall in a cycle where `mr` is 1 is discarded. After `mr` returns to 0, `q` reads 0.
- R3: The divide-by-5 section is `q[3:1]`, read as an unsigned binary value with `q[3]` as the most significant bit. It steps 0,1,2,3,4 and then back to 0.
- R4: The divide-by-2 section is `q[0]`. It toggles on each advance of that section.
- R5: With `mode`=0, each fall of `cp0` adds one to `q`, read as a 4-bit binary value, in the order 0..9 and then back to 0. Falls of `cp1` have no effect in this mode.
- R6: With `mode`=1, each fall of `cp1` steps the divide-by-5 section. The fall of `q[3]` toggles `q[0]`, so `q` reads 2,4,6,8,1,3,5,7,9,0 after the falls that follow a reset. `q[0]` is 1 for exactly 5 of 10 input periods. Falls of `cp0` have no effect in this mode.
- R7: In both modes, `q[3]` is 1 for exactly 2 of every 10 input periods. In mode 1 this is one period in five.
- R8: All bits of `q` change together on the third rising `clk` edge after the count input falls, and not before.
- R9: On the clock edge where the count wraps from `q[0]`=1, `q[3:1]`=4 to zero, `tc` goes to 1 for exactly one clock cycle, with `q`=0 during that cycle.
- R10: A count input that is held low for many clock cycles counts only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| mr | input | 1 | Master reset, active high, sampled on `clk` |
| mode | input | 1 | Chaining select: 0 = decade 8-4-2-1, 1 = symmetric divide-by-10 |
| cp0 | input | 1 | Count input of the divide-by-2 section, falling edge active |
| cp1 | input | 1 | Count input of the divide-by-5 section, falling edge active |
| q | output | 4 | Counter outputs: `q[0]` is the divide-by-2 stage, `q[3:1]` the divide-by-5 stage |
| tc | output | 1 | One-cycle pulse when the combined count wraps to zero |

## Verification
A count-input fall driven just after clock edge N is due on `q` after rising edge N+3: two edges pass through the synchronizer and one through the counter register. The `tc` pulse is due on the same edge and clears after edge N+4. The driver task records the cycle number when it changes an input and pushes expectations due at N+2 (the old value, which must still be present), N+3 and N+4. The monitor compares each expectation only at the falling clock edge where the cycle counter matches its due cycle. Reset, priority and duty-cycle checks wait until the queue is empty, so that they sample only settled outputs.

// File: rtl/dd_pkg.sv
package dd_pkg;

    typedef enum logic {
        MODE_DECADE    = 1'b0,
        MODE_SYMMETRIC = 1'b1
    } dd_mode_e;

    localparam int unsigned DD_LO_MOD = 2;
    localparam int unsigned DD_HI_MOD = 5;

endpackage

// File: rtl/dd_edge_sync.sv
module dd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              hist;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.hist = st_q.sync[STAGES-1];
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fall_o = st_q.hist & ~st_q.sync[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (clr)
        fall_o |=> !fall_o); // R10

    initial begin
        AST_STAGES_MIN: assert (STAGES >= 2); // R8
    end

endmodule

// File: rtl/dd_modn.sv
module dd_modn #(
    parameter  int unsigned MODULUS = 5,
    localparam int unsigned W       = (MODULUS > 2) ? $clog2(MODULUS) : 1
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (clr)
        cnt_o <= LAST); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
        !adv |=> $stable(cnt_o)); // R1

endmodule

// File: rtl/decade_divider.sv
module decade_divider
    import dd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       mr,
    input  logic       mode,
    input  logic       cp0,
    input  logic       cp1,
    output logic [3:0] q,
    output logic       tc
);

    localparam int unsigned N_IN = 2;
    localparam int unsigned HI_W = $clog2(DD_HI_MOD);
    localparam logic [HI_W-1:0] HI_LAST = HI_W'(DD_HI_MOD - 1);

    typedef struct packed {
        logic tc;
    } top_state_t;

    logic [N_IN-1:0] cp_in;
    logic [N_IN-1:0] fall;
    logic            lo_cnt;
    logic [HI_W-1:0] hi_cnt;
    logic            adv_lo, adv_hi;
    logic            decade_carry, sym_carry;
    dd_mode_e        mode_e;
    top_state_t      st_d, st_q;

    assign cp_in  = {cp1, cp0};
    assign mode_e = dd_mode_e'(mode);

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        dd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .clr    (mr),
            .din    (cp_in[i]),
            .fall_o (fall[i])
        );
    end

    // A stage output falls exactly when it is at its last value and advances.
    assign decade_carry = fall[0] & lo_cnt;
    assign sym_carry    = fall[1] & (hi_cnt == HI_LAST);

    always_comb begin
        if (mode_e == MODE_DECADE) begin
            adv_lo = fall[0];
            adv_hi = decade_carry;
        end else begin
            adv_lo = sym_carry;
            adv_hi = fall[1];
        end
    end

    dd_modn #(.MODULUS(DD_LO_MOD)) u_lo (
        .clk   (clk),
        .clr   (mr),
        .adv   (adv_lo),
        .cnt_o (lo_cnt)
    );

    dd_modn #(.MODULUS(DD_HI_MOD)) u_hi (
        .clk   (clk),
        .clr   (mr),
        .adv   (adv_hi),
        .cnt_o (hi_cnt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.tc = adv_lo & adv_hi & lo_cnt & (hi_cnt == HI_LAST);
        if (mr) begin
            st_d.tc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q  = {hi_cnt, lo_cnt};
    assign tc = st_q.tc;

    AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (mr)
        tc |-> (q == 4'd0)); // R9

    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (mr)
        tc |=> !tc); // R9

    AST_MR_CLEARS: assert property (@(posedge clk) disable iff (mr)
        $fell(mr) |-> (q == 4'd0 && !tc)); // R2

    AST_DECADE_IGNORES: assert property (@(posedge clk) disable iff (mr)
        (mode_e == MODE_DECADE && !fall[0]) |=> $stable(q)); // R5

    AST_SYM_IGNORES: assert property (@(posedge clk) disable iff (mr)
        (mode_e == MODE_SYMMETRIC && !fall[1]) |=> $stable(q)); // R6

endmodule

// File: tb/decade_divider_bench.sv
`timescale 1ns/1ps
module decade_divider_bench;

    typedef struct {
        int         due;
        logic [3:0] q;
        logic       tc;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       mr  = 1'b1;
    logic       mode = 1'b0;
    logic       cp0 = 1'b1;
    logic       cp1 = 1'b1;
    logic [3:0] q;
    logic       tc;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb[$];

    int m_lo = 0;
    int m_hi = 0;

    decade_divider u_decade_divider (
        .clk  (clk),
        .mr   (mr),
        .mode (mode),
        .cp0  (cp0),
        .cp1  (cp1),
        .q    (q),
        .tc   (tc)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] model_q();
        return {3'(m_hi), 1'(m_lo)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int due, input logic t, input string tag);
        item_t it;
        it.due = due;
        it.q   = model_q();
        it.tc  = t;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Falls then rises one count input; pushes the expected results.
    task automatic pulse(input bit on_cp1, input int low_len, input string tag);
        int  base;
        bit  wrap;
        wrap = 0;
        @(negedge clk);
        if (on_cp1) cp1 = 1'b0; else cp0 = 1'b0;
        base = cyc;
        push(base + 2, 1'b0, "R8 early");
        if (mode == 1'b0 && !on_cp1) begin
            if (m_lo == 1) begin
                if (m_hi == 4) wrap = 1;
                m_hi = (m_hi + 1) % 5;
            end
            m_lo = 1 - m_lo;
        end else if (mode == 1'b1 && on_cp1) begin
            if (m_hi == 4) begin
                if (m_lo == 1) wrap = 1;
                m_lo = 1 - m_lo;
            end
            m_hi = (m_hi + 1) % 5;
        end
        push(base + 3, wrap, tag);
        push(base + 4, 1'b0, "R9 tc clear");
        repeat (low_len) @(negedge clk);
        if (on_cp1) cp1 = 1'b1; else cp0 = 1'b1;
        base = cyc;
        push(base + 4, 1'b0, "R1 rise");
        repeat (5) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        drain();
        @(negedge clk);
        mr   = 1'b1;
        mode = m;
        cp0  = 1'b1;
        cp1  = 1'b1;
        repeat (3) @(negedge clk);
        chk(q == 4'd0 && tc == 1'b0, "R2 held", q, 0);
        mr = 1'b0;
        m_lo = 0;
        m_hi = 0;
        @(negedge clk);
        chk(q == 4'd0 && tc == 1'b0, "R2 release", q, 0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.due != cyc || q !== it.q || tc !== it.tc) begin
                errors++;
                $display("FAIL %s actual q=%0d tc=%0d expected q=%0d tc=%0d (cycle %0d due %0d)",
                         it.tag, q, tc, it.q, it.tc, cyc, it.due);
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int ones0, ones3;
        int sym_seq[10] = '{2, 4, 6, 8, 1, 3, 5, 7, 9, 0};

        repeat (2) @(negedge clk);
        chk(q == 4'd0 && tc == 1'b0, "R2 reset state", q, 0);

        // Decade mode: full sequence and duty.
        do_reset(1'b0);
        ones0 = 0;
        ones3 = 0;
        for (int k = 1; k <= 10; k++) begin
            pulse(1'b0, 4, "R5 decade step");
            drain();
            chk(q == 4'(k % 10), "R5 decade value", q, k % 10);
            ones0 += int'(q[0]);
            ones3 += int'(q[3]);
        end
        chk(ones0 == 5, "R4 q0 periods high", ones0, 5);
        chk(ones3 == 2, "R7 q3 periods high decade", ones3, 2);

        // Decade mode: cp1 ignored, long low counts once.
        pulse(1'b0, 4, "R5 decade step");
        pulse(1'b0, 4, "R5 decade step");
        pulse(1'b1, 4, "R5 cp1 ignored");
        drain();
        chk(q == 4'd2, "R5 cp1 ignored", q, 2);
        pulse(1'b0, 30, "R10 long low");
        drain();
        chk(q == 4'd3, "R10 long low", q, 3);

        // Reset priority over a pending edge.
        @(negedge clk);
        cp0 = 1'b0;
        repeat (2) @(negedge clk);
        mr = 1'b1;
        repeat (2) @(negedge clk);
        cp0 = 1'b1;
        repeat (2) @(negedge clk);
        mr = 1'b0;
        m_lo = 0;
        m_hi = 0;
        repeat (6) @(negedge clk);
        chk(q == 4'd0 && tc == 1'b0, "R2 priority", q, 0);

        // Symmetric mode: sequence and duty.
        do_reset(1'b1);
        ones0 = 0;
        ones3 = 0;
        for (int k = 0; k < 10; k++) begin
            pulse(1'b1, 4, "R6 symmetric step");
            drain();
            chk(q == 4'(sym_seq[k]), "R6 symmetric value", q, sym_seq[k]);
            ones0 += int'(q[0]);
            ones3 += int'(q[3]);
        end
        chk(ones0 == 5, "R6 q0 half duty", ones0, 5);
        chk(ones3 == 2, "R7 q3 fifth duty", ones3, 2);

        // Divide-by-5 field alone.
        for (int k = 1; k <= 4; k++) begin
            pulse(1'b1, 4, "R3 div5 step");
            drain();
            chk(q[3:1] == 3'(k), "R3 div5 field", q[3:1], k);
        end
        pulse(1'b0, 4, "R6 cp0 ignored");
        drain();
        chk(q == 4'd8, "R6 cp0 ignored", q, 8);

        drain();
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule